// File: doc/BRIEF.md
# Victim Line Buffer

A small fully associative store placed between a direct-mapped first-level cache and the next memory level. It keeps whole lines that the first level has recently thrown out, so that two blocks fighting over the same direct-mapped slot do not both have to go to the slow memory. Each line is known only by its full block-address tag. The word offset inside the line is handled by the first level. Because any line may sit in any entry, every lookup compares the requested tag against all entries in the same cycle.

When the first level misses, it presents the block tag on the lookup port. On a hit, the buffer returns the line and its dirty flag and drops its own copy. In that same cycle the first level may hand over the line it is displacing, and that line takes the freed entry. On a miss, the buffer forwards the tag to the next level. Lines displaced from the first level arrive on the insert port. They go first into a free entry. When every entry is full, a round-robin pointer picks the entry to replace, and a dirty line pushed out this way leaves on the write-back port.

Top module: `victim_buf`

## Requirements
- R1: After reset every entry is empty, so any lookup misses, and `resp_valid`, `fwd_valid` and `wb_valid` are low.
- R2: A lookup of a tag held in a valid entry sets `resp_valid` and `resp_hit` one cycle later and returns that entry's line on `resp_data` and its dirty flag on `resp_dirty`.
- R3: All entries are compared with the lookup tag at once. A lookup that matches no valid entry gives `resp_valid`=1 and `resp_hit`=0 one cycle later, and in that same cycle `fwd_valid`=1 with the lookup tag on `fwd_tag`.
- R4: The entry that a lookup hits is invalidated, so a second lookup of the same tag misses unless that tag was inserted in between.
- R5: An insert issued in the same cycle as a lookup hit is written into the entry that the hit frees (swap), so it never causes a replacement or a write-back, even when the buffer is full.
- R6: An insert with a new tag fills the lowest-numbered empty entry when one exists. No entry is replaced and no write-back occurs.
- R7: When all entries are valid, an insert with a new tag replaces the entry under a round-robin pointer. The pointer starts at entry 0 after reset and advances by one, wrapping after entry ENTRIES-1, only on such a replacement.
- R8: An insert whose tag matches a valid entry overwrites that entry's line. No second copy is made. The dirty flag becomes the OR of the old flag and the new one, and nothing is written back.
- R9: When a replacement pushes out a dirty line, `wb_valid` is high one cycle after the insert, with the old tag and line on `wb_tag` and `wb_data`. Pushing out a clean line gives no write-back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lookup_valid | input | 1 | First-level miss presents a tag for lookup |
| lookup_tag | input | TAG_W | Block-address tag to look up |
| ins_valid | input | 1 | First level hands over a displaced line |
| ins_tag | input | TAG_W | Tag of the displaced line |
| ins_data | input | LINE_W | Displaced line contents |
| ins_dirty | input | 1 | Displaced line was modified |
| resp_valid | output | 1 | Lookup answer valid (one cycle after lookup) |
| resp_hit | output | 1 | Lookup found the tag |
| resp_data | output | LINE_W | Line returned on a hit, zero on a miss |
| resp_dirty | output | 1 | Dirty flag of the returned line |
| fwd_valid | output | 1 | Miss forwarded to next level |
| fwd_tag | output | TAG_W | Tag forwarded on a miss |
| wb_valid | output | 1 | Dirty line pushed out to next level |
| wb_tag | output | TAG_W | Tag of the pushed-out line |
| wb_data | output | LINE_W | Contents of the pushed-out line |

## Verification
Each result has a fixed latency. The lookup answer and the miss forward come one clock edge after the lookup is presented. The write-back comes one edge after the insert that caused the replacement. Storage changes made at that edge show up in the answer to any later lookup. The bench drives every request just after a falling edge and reads all outputs at the next falling edge. Before it advances, it computes what each output should be from a slot-level model of the fill order, the swap rule and the round-robin pointer.

// File: rtl/vc_pkg.sv
// Package: shared types for the victim line buffer.
// Assumes: nothing beyond standard SystemVerilog.
package vc_pkg;
    // Where an inserted line goes, in priority order.
    typedef enum logic [1:0] {
        FILL_SAME_TAG = 2'd0,   // tag already present: overwrite in place
        FILL_SWAP     = 2'd1,   // take the entry freed by a same-cycle hit
        FILL_FREE     = 2'd2,   // lowest empty entry
        FILL_EVICT    = 2'd3    // replace entry under round-robin pointer
    } fill_src_e;
endpackage

// File: rtl/vc_tag_match.sv
// Module: vc_tag_match
// Compares one key against every entry tag in parallel and reports the
// matching entry. Assumes at most one valid entry carries any given tag.
module vc_tag_match #(
    parameter int ENTRIES = 8,
    parameter int TAG_W   = 8,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ENTRIES-1:0]       valid,
    input  logic [ENTRIES*TAG_W-1:0] tags,
    input  logic [TAG_W-1:0]         key,
    output logic [ENTRIES-1:0]       match,
    output logic                     any,
    output logic [IDX_W-1:0]         idx
);
    // One comparator per entry.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match[g] = valid[g] && (tags[g*TAG_W +: TAG_W] == key);
    end

    assign any = |match;

    // Encode the matching entry number.
    always_comb begin
        idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (match[i]) idx = IDX_W'(i);
        end
    end

    // R8: duplicates are never created, so at most one entry matches.
    assert_single_match_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match));
endmodule

// File: rtl/vc_victim_sel.sv
// Module: vc_victim_sel
// Finds the lowest empty entry and keeps the round-robin replacement
// pointer. Assumes advance is raised only when all entries are valid.
module vc_victim_sel #(
    parameter int ENTRIES = 8,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ENTRIES-1:0] valid,
    input  logic               advance,
    output logic               free_any,
    output logic [IDX_W-1:0]   free_idx,
    output logic [IDX_W-1:0]   rr_idx
);
    logic [IDX_W-1:0] rr_q;

    assign free_any = ~&valid;
    assign rr_idx   = rr_q;

    // Lowest-numbered empty entry.
    always_comb begin
        free_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!valid[i]) free_idx = IDX_W'(i);
        end
    end

    // Round-robin pointer moves only on a replacement.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rr_q <= '0;
        end else if (advance) begin
            rr_q <= (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
        end
    end

    // R7: pointer stays within the entry range.
    assert_rr_in_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rr_q <= IDX_W'(ENTRIES - 1));

    // R7: pointer changes only after a replacement.
    assert_rr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !advance |=> $stable(rr_q));

    // R6: replacement only happens with no empty entry.
    assert_full_before_evict_R6: assert property (@(posedge clk) disable iff (!rst_n)
        advance |-> !free_any);
endmodule

// File: rtl/victim_buf.sv
// Module: victim_buf (top)
// Fully associative buffer of lines evicted from a direct-mapped cache.
// Lookups answer one cycle later; a hit removes the line, and a same-cycle
// insert takes the freed entry. Assumes tags are full block addresses.
module victim_buf #(
    parameter int ENTRIES = 8,
    parameter int TAG_W   = 8,
    parameter int LINE_W  = 32,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lookup_valid,
    input  logic [TAG_W-1:0]  lookup_tag,
    input  logic              ins_valid,
    input  logic [TAG_W-1:0]  ins_tag,
    input  logic [LINE_W-1:0] ins_data,
    input  logic              ins_dirty,
    output logic              resp_valid,
    output logic              resp_hit,
    output logic [LINE_W-1:0] resp_data,
    output logic              resp_dirty,
    output logic              fwd_valid,
    output logic [TAG_W-1:0]  fwd_tag,
    output logic              wb_valid,
    output logic [TAG_W-1:0]  wb_tag,
    output logic [LINE_W-1:0] wb_data
);
    import vc_pkg::*;

    initial begin
        assert (ENTRIES >= 4 && ENTRIES <= 16)
            else $error("victim_buf: ENTRIES must be 4..16");
    end

    // Entry storage.
    logic [TAG_W-1:0]         ent_tag  [ENTRIES];
    logic [LINE_W-1:0]        ent_data [ENTRIES];
    logic [ENTRIES-1:0]       ent_valid;
    logic [ENTRIES-1:0]       ent_dirty;
    logic [ENTRIES*TAG_W-1:0] tag_flat;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_flat
        assign tag_flat[g*TAG_W +: TAG_W] = ent_tag[g];
    end

    // Lookup and duplicate-insert searches.
    logic [ENTRIES-1:0] hit_vec, dup_vec;
    logic               hit_any, dup_any;
    logic [IDX_W-1:0]   hit_idx, dup_idx;

    vc_tag_match #(.ENTRIES(ENTRIES), .TAG_W(TAG_W)) lookup_cmp_i (
        .clk(clk), .rst_n(rst_n), .valid(ent_valid), .tags(tag_flat),
        .key(lookup_tag), .match(hit_vec), .any(hit_any), .idx(hit_idx));

    vc_tag_match #(.ENTRIES(ENTRIES), .TAG_W(TAG_W)) insert_cmp_i (
        .clk(clk), .rst_n(rst_n), .valid(ent_valid), .tags(tag_flat),
        .key(ins_tag), .match(dup_vec), .any(dup_any), .idx(dup_idx));

    // Free-entry search and replacement pointer.
    logic             free_any, evict_now;
    logic [IDX_W-1:0] free_idx, rr_idx;

    vc_victim_sel #(.ENTRIES(ENTRIES)) sel_i (
        .clk(clk), .rst_n(rst_n), .valid(ent_valid), .advance(evict_now),
        .free_any(free_any), .free_idx(free_idx), .rr_idx(rr_idx));

    logic      look_hit;
    fill_src_e fill_src;
    logic [IDX_W-1:0] fill_idx;

    assign look_hit = lookup_valid && hit_any;

    // Choose where an inserted line goes.
    always_comb begin
        if (dup_any) begin
            fill_src = FILL_SAME_TAG;
            fill_idx = dup_idx;
        end else if (look_hit) begin
            fill_src = FILL_SWAP;
            fill_idx = hit_idx;
        end else if (free_any) begin
            fill_src = FILL_FREE;
            fill_idx = free_idx;
        end else begin
            fill_src = FILL_EVICT;
            fill_idx = rr_idx;
        end
    end

    assign evict_now = ins_valid && (fill_src == FILL_EVICT);

    // Valid and dirty flags: hit invalidates, insert (later) overrides.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_valid <= '0;
            ent_dirty <= '0;
        end else begin
            if (look_hit) ent_valid[hit_idx] <= 1'b0;
            if (ins_valid) begin
                ent_valid[fill_idx] <= 1'b1;
                ent_dirty[fill_idx] <= ins_dirty ||
                    ((fill_src == FILL_SAME_TAG) && ent_dirty[fill_idx]);
            end
        end
    end

    // Tag and line payload, written on insert.
    always_ff @(posedge clk) begin
        if (ins_valid) begin
            ent_tag[fill_idx]  <= ins_tag;
            ent_data[fill_idx] <= ins_data;
        end
    end

    // Lookup answer and miss forward, one cycle after the lookup.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid <= 1'b0;
            resp_hit   <= 1'b0;
            resp_data  <= '0;
            resp_dirty <= 1'b0;
            fwd_valid  <= 1'b0;
            fwd_tag    <= '0;
        end else begin
            resp_valid <= lookup_valid;
            resp_hit   <= look_hit;
            resp_data  <= look_hit ? ent_data[hit_idx] : '0;
            resp_dirty <= look_hit && ent_dirty[hit_idx];
            fwd_valid  <= lookup_valid && !hit_any;
            fwd_tag    <= lookup_tag;
        end
    end

    // Write-back of a dirty line pushed out by a replacement.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wb_valid <= 1'b0;
            wb_tag   <= '0;
            wb_data  <= '0;
        end else begin
            wb_valid <= evict_now && ent_dirty[rr_idx];
            wb_tag   <= ent_tag[rr_idx];
            wb_data  <= ent_data[rr_idx];
        end
    end

    // R2: every lookup is answered exactly one cycle later.
    assert_resp_follows_lookup_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (resp_valid == $past(lookup_valid)));

    // R3: a forward appears exactly for answered misses.
    assert_fwd_on_miss_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_valid == (resp_valid && !resp_hit));

    // R4: a hit entry is empty afterwards unless an insert refilled it.
    assert_hit_removed_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (look_hit && !ins_valid) |=> !ent_valid[$past(hit_idx)]);

    // R5: a swap never produces a write-back.
    assert_swap_no_wb_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (look_hit && ins_valid) |=> !wb_valid);

    // R9: write-back only follows an insert into a full buffer.
    assert_wb_after_insert_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> ($past(ins_valid) && $past(&ent_valid)));
endmodule

// File: tb/victim_buf_tb.sv
module victim_buf_tb_top;
    localparam int ENTRIES = 8;
    localparam int TAG_W   = 8;
    localparam int LINE_W  = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lookup_valid = 1'b0;
    logic [TAG_W-1:0] lookup_tag = '0;
    logic ins_valid = 1'b0;
    logic [TAG_W-1:0] ins_tag = '0;
    logic [LINE_W-1:0] ins_data = '0;
    logic ins_dirty = 1'b0;
    logic resp_valid, resp_hit, resp_dirty, fwd_valid, wb_valid;
    logic [LINE_W-1:0] resp_data, wb_data;
    logic [TAG_W-1:0] fwd_tag, wb_tag;

    always #2 clk = ~clk;  // 250 MHz

    victim_buf #(.ENTRIES(ENTRIES), .TAG_W(TAG_W), .LINE_W(LINE_W)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .lookup_valid(lookup_valid), .lookup_tag(lookup_tag),
        .ins_valid(ins_valid), .ins_tag(ins_tag), .ins_data(ins_data),
        .ins_dirty(ins_dirty),
        .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_data(resp_data),
        .resp_dirty(resp_dirty), .fwd_valid(fwd_valid), .fwd_tag(fwd_tag),
        .wb_valid(wb_valid), .wb_tag(wb_tag), .wb_data(wb_data));

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    // Slot-level reference model built from the requirements.
    logic [TAG_W-1:0]  m_tag  [ENTRIES];
    logic [LINE_W-1:0] m_data [ENTRIES];
    bit m_v [ENTRIES];
    bit m_d [ENTRIES];
    int m_ptr;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int find_tag(input logic [TAG_W-1:0] t);
        for (int i = 0; i < ENTRIES; i++)
            if (m_v[i] && m_tag[i] == t) return i;
        return -1;
    endfunction

    function automatic int first_free();
        for (int i = 0; i < ENTRIES; i++)
            if (!m_v[i]) return i;
        return -1;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < ENTRIES; i++) begin
            m_v[i] = 1'b0;
            m_d[i] = 1'b0;
            m_tag[i] = '0;
            m_data[i] = '0;
        end
        m_ptr = 0;
    endtask

    // One request cycle: drive after a falling edge, check at the next one.
    task automatic step(input string req, input bit lv, input logic [TAG_W-1:0] lt,
                        input bit iv, input logic [TAG_W-1:0] it,
                        input logic [LINE_W-1:0] id, input bit idy);
        int h, d, tgt;
        bit e_hit, e_dirty, e_wb;
        logic [LINE_W-1:0] e_data, e_wbd;
        logic [TAG_W-1:0] e_wbt;
        lookup_valid = lv; lookup_tag = lt;
        ins_valid = iv; ins_tag = it; ins_data = id; ins_dirty = idy;
        h = lv ? find_tag(lt) : -1;
        e_hit = (h >= 0);
        e_data = e_hit ? m_data[h] : '0;
        e_dirty = e_hit ? m_d[h] : 1'b0;
        e_wb = 1'b0; e_wbt = '0; e_wbd = '0;
        tgt = -1;
        if (iv) begin
            d = find_tag(it);
            if (d >= 0) begin
                tgt = d;
                m_d[d] = m_d[d] | idy;
            end else begin
                if (e_hit) tgt = h;
                else if (first_free() >= 0) tgt = first_free();
                else begin
                    tgt = m_ptr;
                    e_wb = m_d[tgt]; e_wbt = m_tag[tgt]; e_wbd = m_data[tgt];
                    m_ptr = (m_ptr == ENTRIES - 1) ? 0 : m_ptr + 1;
                end
                m_d[tgt] = idy;
            end
        end
        if (e_hit && h != tgt) m_v[h] = 1'b0;
        if (tgt >= 0) begin
            m_v[tgt] = 1'b1; m_tag[tgt] = it; m_data[tgt] = id;
        end
        @(negedge clk);
        chk(resp_valid == lv, req, "resp_valid", 64'(resp_valid), 64'(lv));
        if (lv) begin
            chk(resp_hit == e_hit, req, "resp_hit", 64'(resp_hit), 64'(e_hit));
            if (e_hit) begin
                chk(resp_data == e_data, req, "resp_data", 64'(resp_data), 64'(e_data));
                chk(resp_dirty == e_dirty, req, "resp_dirty", 64'(resp_dirty), 64'(e_dirty));
            end
            chk(fwd_valid == !e_hit, req, "fwd_valid", 64'(fwd_valid), 64'(!e_hit));
            if (!e_hit) chk(fwd_tag == lt, req, "fwd_tag", 64'(fwd_tag), 64'(lt));
        end else begin
            chk(fwd_valid == 1'b0, req, "fwd_valid idle", 64'(fwd_valid), 64'(0));
        end
        chk(wb_valid == e_wb, req, "wb_valid", 64'(wb_valid), 64'(e_wb));
        if (e_wb) begin
            chk(wb_tag == e_wbt, req, "wb_tag", 64'(wb_tag), 64'(e_wbt));
            chk(wb_data == e_wbd, req, "wb_data", 64'(wb_data), 64'(e_wbd));
        end
        lookup_valid = 1'b0; ins_valid = 1'b0;
    endtask

    task automatic look(input string req, input logic [TAG_W-1:0] t);
        step(req, 1'b1, t, 1'b0, '0, '0, 1'b0);
    endtask

    task automatic put(input string req, input logic [TAG_W-1:0] t, input bit dy);
        step(req, 1'b0, '0, 1'b1, t, {8'hA5, 16'h0, t}, dy);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(negedge clk);
        // R1: reset state of the outputs.
        chk(!resp_valid && !fwd_valid && !wb_valid, "R1", "outputs in reset",
            64'({resp_valid, fwd_valid, wb_valid}), 64'(0));
        rst_n = 1'b1;
        @(negedge clk);
        look("R1", 8'h20);
        look("R3", 8'h77);
        // R6: fill every entry without replacement.
        for (int i = 0; i < ENTRIES; i++) put("R6", 8'(8'h20 + i), i[0]);
        look("R2", 8'h23);          // hit, dirty line
        look("R2", 8'h24);          // hit, clean line
        look("R4", 8'h23);          // removed by previous hit
        put("R6", 8'h40, 1'b1);     // fills freed slot 3
        put("R6", 8'h41, 1'b0);     // fills freed slot 4
        put("R7", 8'h42, 1'b1);     // replaces entry 0 (clean 0x20)
        put("R9", 8'h43, 1'b0);     // replaces entry 1 (dirty 0x21)
        look("R7", 8'h20);          // gone
        step("R5", 1'b1, 8'h25, 1'b1, 8'h50, 32'hCAFE_0050, 1'b1); // swap, full
        look("R5", 8'h50);
        look("R5", 8'h26);
        step("R8", 1'b0, '0, 1'b1, 8'h27, 32'h1234_5678, 1'b0);   // dup of dirty 0x27
        look("R8", 8'h27);
        step("R8", 1'b1, 8'h22, 1'b1, 8'h22, 32'h0BAD_0022, 1'b0); // hit + same tag
        look("R8", 8'h22);
        // Random mix over a narrow tag range.
        for (int n = 0; n < 4000; n++) begin
            bit lv, iv;
            logic [TAG_W-1:0] lt, it;
            lv = ($urandom % 2) == 0;
            iv = ($urandom % 2) == 0;
            lt = 8'(8'h60 + ($urandom % 16));
            it = 8'(8'h60 + ($urandom % 16));
            step("R7", lv, lt, iv, it, $urandom, 1'($urandom));
        end
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule